// File: doc/BRIEF.md
# Dual-Channel Interleaved Pulse Timing Sequencer

This block produces the timing for a two-channel pulse-induction metal detector front end from a single system clock. Each channel has its own slot counter with its own even cycle length, between 10 and 18 slots. A channel drives its transmit-enable line during a configurable number of slots at the start of each cycle. It raises four sample strobes (target, ground-balance, early-field 1, early-field 2) in slots chosen from the slots that follow the transmit slots.

An interleave controller lets the active channel run a programmable number of complete cycles, from 1 to 9. It then hands over to the other channel, and the handover only happens at a cycle boundary. The two channels can therefore run in any cycle ratio, and because their sample timing differs, their blind spots fall in different places. Either channel can also be run alone.

All settings are sampled from the configuration ports while `run_i` is low. While `run_i` is high, the sequencer runs, and changes on the configuration ports have no effect until the next idle period.

Top module: `pi_dual_sequencer`

## Requirements
- R1: After reset, and in every clock where `run_i` is low, all outputs are low. Configuration ports are sampled only in clocks where `run_i` is low. Changes while running have no effect on the outputs.
- R2: A cycle length is clamped to the range 10..18 and then has bit 0 cleared. For example, 11 becomes 10, 25 becomes 18 and 3 becomes 10. A channel's slot index stays below its cycle length and returns to slot 0 after the last slot.
- R3: A transmit-slot count of 0 is treated as 1, and a count above 9 is treated as 9. The active channel's `tx_en_o` bit is high in exactly slots 0..T-1 of each of its cycles, where T is the treated count.
- R4: Each 20-bit position port packs four 5-bit slot numbers: bits [4:0] target, [9:5] ground-balance, [14:10] early-field 1, [19:15] early-field 2. A strobe is high for one clock in the slot equal to its position, but only when that position is at least T and below the cycle length. Otherwise the strobe never fires. A strobe and its channel's transmit-enable are never high together.
- R5: Mode value 0 selects interleaving. Channel A (bit 0 of each output pair) starts, runs N_A full cycles, then channel B runs N_B full cycles, and so on. A repeat count of 0 is treated as 1, and a count above 9 is treated as 9. The active channel changes only at a cycle boundary.
- R6: Mode 1 runs channel A alone. Mode 2 runs channel B alone. Mode 3 behaves as mode 1.
- R7: The inactive channel's counter stays at slot 0, and all of its outputs stay low.
- R8: At most one bit of `tx_en_o` is high in any clock.
- R9: Outputs are registered. Slot 0 of the starting channel appears at the outputs one clock after the first rising edge where `run_i` is high.
- R10: Lowering `run_i` stops the sequence at any slot. The next run restarts at slot 0 of the starting channel with the repeat count cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | High: sequencer runs; low: idle and configuration sampled |
| mode_i | input | 2 | 0 interleave, 1 channel A alone, 2 channel B alone, 3 as 1 |
| len_a_i | input | 5 | Channel A cycle length in slots |
| len_b_i | input | 5 | Channel B cycle length in slots |
| tx_a_i | input | 4 | Channel A transmit-slot count |
| tx_b_i | input | 4 | Channel B transmit-slot count |
| pos_a_i | input | 20 | Channel A strobe slot positions, packed per R4 |
| pos_b_i | input | 20 | Channel B strobe slot positions, packed per R4 |
| reps_a_i | input | 4 | Channel A full cycles per turn |
| reps_b_i | input | 4 | Channel B full cycles per turn |
| tx_en_o | output | 2 | Transmit enable, bit 0 channel A, bit 1 channel B |
| stb_tgt_o | output | 2 | Target sample strobe per channel |
| stb_gb_o | output | 2 | Ground-balance sample strobe per channel |
| stb_ef1_o | output | 2 | Early-field 1 sample strobe per channel |
| stb_ef2_o | output | 2 | Early-field 2 sample strobe per channel |

## Verification
Every output is the registered decode of the slot state that was current at the preceding rising edge. The decode of slot k of a run is therefore visible one clock after the edge that processes it. A configuration sampled at an idle edge governs the first running edge that follows. The bench model advances its own slot, channel and repeat state at each rising edge, using the inputs the bench drove at the previous falling edge. It stores the expected outputs for that edge and compares them at the next falling edge, so expected and actual values always refer to the same edge. Count checks over whole runs confirm the interleave ratio, single-channel modes and suppressed strobes.

// File: rtl/pi_seq_pkg.sv
package pi_seq_pkg;
  localparam int SLOT_W  = 5;
  localparam int CNT_W   = 4;
  localparam int NSTB    = 4;
  localparam int NCH     = 2;
  localparam int MIN_LEN = 10;
  localparam int MAX_LEN = 18;
  localparam int MAX_TX  = 9;
  localparam int MAX_REP = 9;

  typedef enum logic [1:0] {
    MODE_ALT   = 2'd0,
    MODE_A     = 2'd1,
    MODE_B     = 2'd2,
    MODE_A_ALT = 2'd3
  } seq_mode_e;

  typedef struct packed {
    logic [SLOT_W-1:0]            len;
    logic [SLOT_W-1:0]            tx;
    logic [NSTB-1:0][SLOT_W-1:0]  pos;
    logic [CNT_W-1:0]             reps;
  } chan_cfg_t;

  function automatic logic [SLOT_W-1:0] fix_len(input logic [SLOT_W-1:0] v);
    logic [SLOT_W-1:0] c;
    if (v < SLOT_W'(MIN_LEN))      c = SLOT_W'(MIN_LEN);
    else if (v > SLOT_W'(MAX_LEN)) c = SLOT_W'(MAX_LEN);
    else                           c = v;
    c[0] = 1'b0;
    return c;
  endfunction

  function automatic logic [CNT_W-1:0] fix_cnt(input logic [CNT_W-1:0] v,
                                               input int unsigned hi);
    logic [CNT_W-1:0] c;
    if (v == '0)                 c = CNT_W'(1);
    else if (v > CNT_W'(hi))     c = CNT_W'(hi);
    else                         c = v;
    return c;
  endfunction
endpackage

// File: rtl/pi_seq_slot_ctr.sv
module pi_seq_slot_ctr
  import pi_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [SLOT_W-1:0] len_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              last_o
);
  logic [SLOT_W-1:0] slot_q, slot_d;

  assign last_o = en_i && (slot_q == len_i - 1'b1);
  assign slot_o = slot_q;

  always_comb begin
    slot_d = slot_q;
    if (!en_i)       slot_d = '0;
    else if (last_o) slot_d = '0;
    else             slot_d = slot_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  p_slot_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q < len_i);
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> (slot_q == '0));
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (slot_q == '0));
endmodule

// File: rtl/pi_seq_decode.sv
module pi_seq_decode
  import pi_seq_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en_i,
  input  logic [SLOT_W-1:0]           slot_i,
  input  logic [SLOT_W-1:0]           tx_i,
  input  logic [SLOT_W-1:0]           len_i,
  input  logic [NSTB-1:0][SLOT_W-1:0] pos_i,
  output logic                        tx_o,
  output logic [NSTB-1:0]             stb_o
);
  logic            tx_d;
  logic [NSTB-1:0] stb_d;

  always_comb begin
    tx_d = en_i && (slot_i < tx_i);
    for (int k = 0; k < NSTB; k++) begin
      stb_d[k] = en_i && (slot_i == pos_i[k]) &&
                 (pos_i[k] >= tx_i) && (pos_i[k] < len_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_o  <= 1'b0;
      stb_o <= '0;
    end else begin
      tx_o  <= tx_d;
      stb_o <= stb_d;
    end
  end

  p_tx_strobe_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_o && (|stb_o)));
  p_inactive_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!tx_o && (stb_o == '0)));
endmodule

// File: rtl/pi_seq_interleave.sv
module pi_seq_interleave
  import pi_seq_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       run_i,
  input  logic                       alt_i,
  input  logic                       start_ch_i,
  input  logic [NCH-1:0][CNT_W-1:0]  reps_i,
  input  logic [NCH-1:0]             last_i,
  output logic                       act_o
);
  logic             act_q, act_d;
  logic [CNT_W-1:0] rep_q, rep_d;

  always_comb begin
    act_d = act_q;
    rep_d = rep_q;
    if (!run_i) begin
      act_d = start_ch_i;
      rep_d = '0;
    end else if (last_i[act_q] && alt_i) begin
      if (rep_q == reps_i[act_q] - 1'b1) begin
        act_d = ~act_q;
        rep_d = '0;
      end else begin
        rep_d = rep_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      rep_q <= '0;
    end else begin
      act_q <= act_d;
      rep_q <= rep_d;
    end
  end

  assign act_o = act_q;

  p_rep_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (rep_q < reps_i[act_q]));
  p_switch_at_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q != $past(act_q)) |-> $past(!run_i || (|last_i)));
endmodule

// File: rtl/pi_dual_sequencer.sv
module pi_dual_sequencer
  import pi_seq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run_i,
  input  logic [1:0]             mode_i,
  input  logic [SLOT_W-1:0]      len_a_i,
  input  logic [SLOT_W-1:0]      len_b_i,
  input  logic [CNT_W-1:0]       tx_a_i,
  input  logic [CNT_W-1:0]       tx_b_i,
  input  logic [NSTB*SLOT_W-1:0] pos_a_i,
  input  logic [NSTB*SLOT_W-1:0] pos_b_i,
  input  logic [CNT_W-1:0]       reps_a_i,
  input  logic [CNT_W-1:0]       reps_b_i,
  output logic [NCH-1:0]         tx_en_o,
  output logic [NCH-1:0]         stb_tgt_o,
  output logic [NCH-1:0]         stb_gb_o,
  output logic [NCH-1:0]         stb_ef1_o,
  output logic [NCH-1:0]         stb_ef2_o
);
  chan_cfg_t [NCH-1:0]             cfg_q, cfg_d, cfg_raw;
  logic [1:0]                      mode_q, mode_d;
  logic [NCH-1:0]                  ch_en, ch_last;
  logic [NCH-1:0][SLOT_W-1:0]      ch_slot;
  logic [NCH-1:0][NSTB-1:0]        ch_stb;
  logic [NCH-1:0][CNT_W-1:0]       reps_v;
  logic                            act;

  always_comb begin
    cfg_raw[0].len  = fix_len(len_a_i);
    cfg_raw[1].len  = fix_len(len_b_i);
    cfg_raw[0].tx   = SLOT_W'(fix_cnt(tx_a_i, MAX_TX));
    cfg_raw[1].tx   = SLOT_W'(fix_cnt(tx_b_i, MAX_TX));
    cfg_raw[0].pos  = pos_a_i;
    cfg_raw[1].pos  = pos_b_i;
    cfg_raw[0].reps = fix_cnt(reps_a_i, MAX_REP);
    cfg_raw[1].reps = fix_cnt(reps_b_i, MAX_REP);
  end

  // configuration clock enable: sample only while idle
  always_comb begin
    cfg_d  = cfg_q;
    mode_d = mode_q;
    if (!run_i) begin
      cfg_d  = cfg_raw;
      mode_d = mode_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        cfg_q[c].len  <= SLOT_W'(MIN_LEN);
        cfg_q[c].tx   <= SLOT_W'(1);
        cfg_q[c].pos  <= '0;
        cfg_q[c].reps <= CNT_W'(1);
      end
      mode_q <= MODE_ALT;
    end else begin
      cfg_q  <= cfg_d;
      mode_q <= mode_d;
    end
  end

  pi_seq_interleave u_ilv (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run_i),
    .alt_i      (mode_q == MODE_ALT),
    .start_ch_i (mode_i == MODE_B),
    .reps_i     (reps_v),
    .last_i     (ch_last),
    .act_o      (act)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign ch_en[g]  = run_i && (act == g[0]);
    assign reps_v[g] = cfg_q[g].reps;

    pi_seq_slot_ctr u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (ch_en[g]),
      .len_i  (cfg_q[g].len),
      .slot_o (ch_slot[g]),
      .last_o (ch_last[g])
    );

    pi_seq_decode u_dec (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (ch_en[g]),
      .slot_i (ch_slot[g]),
      .tx_i   (cfg_q[g].tx),
      .len_i  (cfg_q[g].len),
      .pos_i  (cfg_q[g].pos),
      .tx_o   (tx_en_o[g]),
      .stb_o  (ch_stb[g])
    );

    assign stb_tgt_o[g] = ch_stb[g][0];
    assign stb_gb_o[g]  = ch_stb[g][1];
    assign stb_ef1_o[g] = ch_stb[g][2];
    assign stb_ef2_o[g] = ch_stb[g][3];
  end

  p_single_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tx_en_o) <= 1);
  p_idle_outputs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> ((tx_en_o | stb_tgt_o | stb_gb_o | stb_ef1_o | stb_ef2_o) == '0));
  p_one_channel_strobes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|ch_stb[1] | tx_en_o[1], |ch_stb[0] | tx_en_o[0]}));
endmodule

// File: tb/pi_dual_sequencer_tb.sv
module pi_dual_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        run;
  logic [1:0]  mode;
  logic [4:0]  len_a, len_b;
  logic [3:0]  tx_a, tx_b, reps_a, reps_b;
  logic [19:0] pos_a, pos_b;
  logic [1:0]  tx_en, s_tgt, s_gb, s_e1, s_e2;

  int errors = 0;
  int checks = 0;
  string cur_req = "R1 reset";

  // reference model state
  int m_len[2], m_tx[2], m_reps[2], m_pos[2][4];
  int m_mode, m_act, m_slot, m_rep;
  logic [1:0] e_tx, e_tgt, e_gb, e_e1, e_e2;
  int tx_hi[2], stb_hi[2], ef2_hi[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  pi_dual_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .run_i(run), .mode_i(mode),
    .len_a_i(len_a), .len_b_i(len_b), .tx_a_i(tx_a), .tx_b_i(tx_b),
    .pos_a_i(pos_a), .pos_b_i(pos_b), .reps_a_i(reps_a), .reps_b_i(reps_b),
    .tx_en_o(tx_en), .stb_tgt_o(s_tgt), .stb_gb_o(s_gb),
    .stb_ef1_o(s_e1), .stb_ef2_o(s_e2)
  );

  function automatic int lim_len(int v);
    int r;
    r = (v < 10) ? 10 : ((v > 18) ? 18 : v);
    return r - (r % 2);
  endfunction

  function automatic int lim_cnt(int v);
    return (v == 0) ? 1 : ((v > 9) ? 9 : v);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {e_tx, e_tgt, e_gb, e_e1, e_e2} = '0;
      m_act = 0; m_slot = 0; m_rep = 0; m_mode = 0;
      for (int c = 0; c < 2; c++) begin
        m_len[c] = 10; m_tx[c] = 1; m_reps[c] = 1;
        for (int k = 0; k < 4; k++) m_pos[c][k] = 0;
      end
    end else if (!run) begin
      {e_tx, e_tgt, e_gb, e_e1, e_e2} = '0;
      m_len[0] = lim_len(len_a);  m_len[1] = lim_len(len_b);
      m_tx[0]  = lim_cnt(tx_a);   m_tx[1]  = lim_cnt(tx_b);
      m_reps[0] = lim_cnt(reps_a); m_reps[1] = lim_cnt(reps_b);
      for (int k = 0; k < 4; k++) begin
        m_pos[0][k] = (pos_a >> (5*k)) & 31;
        m_pos[1][k] = (pos_b >> (5*k)) & 31;
      end
      m_mode = mode;
      m_act  = (mode == 2) ? 1 : 0;
      m_slot = 0;
      m_rep  = 0;
    end else begin
      logic [3:0] hit;
      for (int k = 0; k < 4; k++)
        hit[k] = (m_slot == m_pos[m_act][k]) && (m_pos[m_act][k] >= m_tx[m_act])
                 && (m_pos[m_act][k] < m_len[m_act]);
      {e_tx, e_tgt, e_gb, e_e1, e_e2} = '0;
      e_tx[m_act]  = (m_slot < m_tx[m_act]);
      e_tgt[m_act] = hit[0];
      e_gb[m_act]  = hit[1];
      e_e1[m_act]  = hit[2];
      e_e2[m_act]  = hit[3];
      if (m_slot == m_len[m_act] - 1) begin
        m_slot = 0;
        if (m_mode == 0) begin
          if (m_rep == m_reps[m_act] - 1) begin
            m_act = 1 - m_act;
            m_rep = 0;
          end else m_rep++;
        end
      end else m_slot++;
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if ({tx_en, s_tgt, s_gb, s_e1, s_e2} !== {e_tx, e_tgt, e_gb, e_e1, e_e2}) begin
        errors++;
        $display("FAIL %s t=%0t actual tx=%b tgt=%b gb=%b e1=%b e2=%b expected tx=%b tgt=%b gb=%b e1=%b e2=%b",
                 cur_req, $time, tx_en, s_tgt, s_gb, s_e1, s_e2, e_tx, e_tgt, e_gb, e_e1, e_e2);
      end
      checks++;
      if (tx_en === 2'b11) begin
        errors++;
        $display("FAIL R8 actual tx=%b expected at most one high", tx_en);
      end
      for (int c = 0; c < 2; c++) begin
        tx_hi[c]  += tx_en[c];
        stb_hi[c] += s_tgt[c] + s_gb[c] + s_e1[c] + s_e2[c];
        ef2_hi[c] += s_e2[c];
      end
    end
  end

  task automatic check_eq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(int md, int la, int lb, int ta, int tb, int ra, int rb,
                     logic [19:0] pa, logic [19:0] pb);
    mode = md[1:0]; len_a = la[4:0]; len_b = lb[4:0];
    tx_a = ta[3:0]; tx_b = tb[3:0]; reps_a = ra[3:0]; reps_b = rb[3:0];
    pos_a = pa; pos_b = pb;
  endtask

  task automatic go(int n);
    @(negedge clk);
    run = 1'b1;
    repeat (n) @(negedge clk);
    run = 1'b0;
    repeat (3) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int b0, b1, s1, e0;
    for (int c = 0; c < 2; c++) begin tx_hi[c] = 0; stb_hi[c] = 0; ef2_hi[c] = 0; end
    rst_n = 1'b0; run = 1'b0;
    // positions packed {ef2, ef1, gb, tgt}
    cfg(0, 18, 16, 3, 5, 1, 4, {5'd9, 5'd5, 5'd16, 5'd14}, {5'd8, 5'd6, 5'd14, 5'd12});
    repeat (3) @(negedge clk);
    // R1: outputs low during reset
    check_eq("R1 reset outputs", int'({tx_en, s_tgt, s_gb, s_e1, s_e2}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R5 / R3 / R4 / R9: 1:4 interleave, four full periods of 18 + 4*16
    cur_req = "R5 interleave 1:4";
    b0 = tx_hi[0]; b1 = tx_hi[1];
    go(4 * 82);
    check_eq("R5 channel A transmit clocks", tx_hi[0] - b0, 4 * 3);
    check_eq("R5 channel B transmit clocks", tx_hi[1] - b1, 4 * 4 * 5);

    // R2 / R3: odd and out-of-range lengths, transmit counts 0 and 12, ratio 2:3
    cur_req = "R2 R3 length and transmit limits";
    cfg(0, 11, 25, 0, 12, 2, 3, {5'd9, 5'd3, 5'd8, 5'd2}, {5'd17, 5'd9, 5'd12, 5'd10});
    b0 = tx_hi[0]; b1 = tx_hi[1];
    go(2 * 10 + 3 * 18);
    check_eq("R3 channel A transmit clocks with count 0", tx_hi[0] - b0, 2 * 1);
    check_eq("R3 channel B transmit clocks with count 12", tx_hi[1] - b1, 3 * 9);

    // R4: strobes at positions inside transmit slots or past the end never fire
    cur_req = "R4 strobe position limits";
    cfg(0, 3, 16, 4, 5, 3, 5, {5'd10, 5'd2, 5'd9, 5'd4}, {5'd16, 5'd4, 5'd15, 5'd5});
    e0 = ef2_hi[0] + ef2_hi[1];
    b1 = stb_hi[1];
    go(3 * 10 + 5 * 16);
    check_eq("R4 out-of-range early-field 2 strobes", ef2_hi[0] + ef2_hi[1] - e0, 0);
    check_eq("R4 channel B strobes (gb and tgt only)", stb_hi[1] - b1, 5 * 2);

    // R6: single-channel modes; R1: port changes while running ignored
    cur_req = "R6 channel A alone";
    cfg(1, 12, 14, 2, 3, 1, 1, {5'd11, 5'd7, 5'd9, 5'd5}, {5'd13, 5'd6, 5'd8, 5'd4});
    b0 = tx_hi[0]; b1 = tx_hi[1]; s1 = stb_hi[1];
    @(negedge clk);
    run = 1'b1;
    repeat (5) @(negedge clk);
    cur_req = "R1 port change while running";
    cfg(2, 18, 18, 9, 9, 9, 9, '0, '0);
    repeat (55) @(negedge clk);
    run = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check_eq("R6 channel B silent in mode 1 transmit", tx_hi[1] - b1, 0);
    check_eq("R6 channel B silent in mode 1 strobes", stb_hi[1] - s1, 0);
    check_eq("R1 mid-run change ignored, A transmit clocks", tx_hi[0] - b0, 5 * 2);

    cur_req = "R6 channel B alone";
    cfg(2, 12, 14, 2, 3, 1, 1, {5'd11, 5'd7, 5'd9, 5'd5}, {5'd13, 5'd6, 5'd8, 5'd4});
    b0 = tx_hi[0]; b1 = tx_hi[1];
    go(4 * 14);
    check_eq("R6 channel A silent in mode 2", tx_hi[0] - b0, 0);
    check_eq("R6 channel B transmit clocks", tx_hi[1] - b1, 4 * 3);

    cur_req = "R6 mode 3 as mode 1";
    cfg(3, 10, 10, 1, 1, 1, 1, {5'd9, 5'd7, 5'd5, 5'd3}, {5'd9, 5'd7, 5'd5, 5'd3});
    b1 = tx_hi[1];
    go(30);
    check_eq("R6 channel B silent in mode 3", tx_hi[1] - b1, 0);

    // R10: stop mid-cycle and restart from slot 0; R7 checked every clock
    cur_req = "R10 stop and restart";
    cfg(0, 16, 18, 4, 2, 2, 1, {5'd15, 5'd6, 5'd10, 5'd8}, {5'd17, 5'd3, 5'd12, 5'd9});
    go(23);
    b0 = tx_hi[0];
    go(3);
    check_eq("R10 restart begins with channel A transmit slots", tx_hi[0] - b0, 3);
    cur_req = "R7 R9 long interleave";
    go(400);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule